// File: doc/BRIEF.md
# Receive Frame FIFO with Error Filtering

This block sits between a network receiver and the DMA engine that moves received frames into memory. Each byte from the receiver enters with a valid strobe. The last byte of a frame also carries two status flags. One flags a MAC-level fault, such as a bad FCS. The other flags a fault that the checksum-offload engine found in the encapsulated payload. The DMA reads bytes through a valid/ready port, and an error flag comes with the last byte of each frame.

The read side has two modes.
- In store-and-forward mode, a frame becomes visible only once all of its bytes are held.
- In cut-through mode, a frame becomes visible once a programmable number of its bytes is held.

When a frame ends, control bits decide whether it is discarded or delivered. If discarded, the write pointer goes back to the frame's first byte and a one-cycle drop pulse is raised. When the downstream side reports that it has no receive buffer, the block either discards the completed frames that are waiting, or keeps them until buffers return.

Top module: `rx_frame_fifo`

## Requirements
- R1: With `store_fwd` high, `out_valid` stays low while a frame is being written and rises the cycle after its last byte is written. `rd_thr` has no effect in this mode.
- R2: With `store_fwd` low, `out_valid` rises the cycle after the frame holds the threshold number of bytes. The threshold comes from `rd_thr`: 0 means 64, 1 means 32, 2 means 96 and 3 means 128. A frame shorter than its threshold becomes visible only after its last byte.
- R3: With `fwd_err_frames` low, a frame whose last byte carries `in_mac_err` is discarded. No byte of it reaches the output, and `frame_drop` pulses for one cycle.
- R4: A frame whose only fault is `in_csum_err` is delivered when `keep_csum_err` is high, with `out_err` set on its last byte. It is discarded when `keep_csum_err` and `fwd_err_frames` are both low. A frame that also carries `in_mac_err` is discarded whatever `keep_csum_err` is, unless `fwd_err_frames` is high.
- R5: With `fwd_err_frames` high, frames with either fault are delivered in full, with `out_err` high on the last byte. `out_err` is low on every other byte.
- R6: In cut-through mode, a faulty frame that has already reached its threshold is not discarded. It is delivered in full, with `out_err` set on its last byte, and `frame_drop` stays low.
- R7: At most DEPTH-1 body bytes of a frame are held; the last byte may use the final slot. When a body byte finds no room, the frame is marked overflowed and its remaining body bytes are ignored. In store-and-forward mode, or in cut-through mode before the threshold, the frame is discarded. Otherwise it is cut short: the bytes held are followed by its last byte with `out_err` set.
- R8: While `no_buf` is high and `hold_on_nobuf` is low, `out_valid` is low. Completed frames that have not started reading are discarded, and `frame_flush` pulses once for each discard. Nothing of them appears once `no_buf` falls.
- R9: While `no_buf` and `hold_on_nobuf` are both high, `out_valid` is low and nothing is discarded. The held frames are delivered unchanged after `no_buf` falls.
- R10: After reset `out_valid`, `frame_drop` and `frame_flush` are low.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values (unless `no_buf` rises).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | DW | Input byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_mac_err | input | 1 | MAC-level fault, sampled with the last byte |
| in_csum_err | input | 1 | Payload checksum-offload fault, sampled with the last byte |
| store_fwd | input | 1 | 1 selects store-and-forward, 0 selects cut-through |
| rd_thr | input | 2 | Cut-through threshold code |
| keep_csum_err | input | 1 | Keep frames whose only fault is a checksum fault |
| fwd_err_frames | input | 1 | Deliver faulty frames instead of discarding them |
| hold_on_nobuf | input | 1 | Keep waiting frames while no buffer is available |
| no_buf | input | 1 | Downstream reports no receive buffer |
| out_ready | input | 1 | Downstream accepts a byte |
| out_valid | output | 1 | Output byte available |
| out_data | output | DW | Output byte |
| out_last | output | 1 | Output byte is the last of its frame |
| out_err | output | 1 | Frame fault, valid with `out_last` |
| frame_drop | output | 1 | One-cycle pulse when a frame is discarded at its end |
| frame_flush | output | 1 | One-cycle pulse when waiting frames are flushed |

## Verification
The bench builds the block with DEPTH set to 256 rather than 2048. This makes overflow reachable with frames of about 300 bytes, and it still leaves room for the largest threshold of 128 bytes plus a margin. As a result, every threshold code can be timed byte by byte. The overflow cases are then reached in both modes: in store-and-forward the frame is discarded, and in cut-through, once the frame is open, it is cut short and flagged. Random frames mix both modes, all four thresholds, both keep and forward settings, and both fault flags.

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo #(
  parameter int DEPTH = 2048,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  input  logic          in_mac_err,
  input  logic          in_csum_err,
  input  logic          store_fwd,
  input  logic [1:0]    rd_thr,
  input  logic          keep_csum_err,
  input  logic          fwd_err_frames,
  input  logic          hold_on_nobuf,
  input  logic          no_buf,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          out_err,
  output logic          frame_drop,
  output logic          frame_flush
);
  localparam int AW = $clog2(DEPTH);
  localparam int MW = DW + 2;
  localparam logic [AW:0] ONE = (AW+1)'(1);
  localparam logic [AW:0] BODY_MAX = (AW+1)'(DEPTH - 1);

  logic [MW-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr, commit_ptr, rd_ptr;
  logic ovf_r, open_r, rd_mid;
  logic [8:0] thr_bytes;

  always_comb begin
    case (rd_thr)
      2'd0: thr_bytes = 9'd64;
      2'd1: thr_bytes = 9'd32;
      2'd2: thr_bytes = 9'd96;
      default: thr_bytes = 9'd128;
    endcase
  end

  wire [AW:0] used      = wr_ptr - rd_ptr;
  wire [AW:0] frame_cnt = wr_ptr - commit_ptr;
  wire open_now = open_r | (!store_fwd && (32'(frame_cnt) >= 32'(thr_bytes)));
  wire [AW:0] limit = open_now ? wr_ptr : commit_ptr;

  wire [MW-1:0] rd_word = mem[rd_ptr[AW-1:0]];
  assign out_valid = (rd_ptr != limit) & !no_buf;
  assign out_data  = rd_word[DW-1:0];
  assign out_last  = rd_word[DW];
  assign out_err   = rd_word[DW+1];
  wire pop = out_valid & out_ready;

  wire any_err   = in_mac_err | in_csum_err;
  wire discard   = ovf_r | ((in_mac_err | (in_csum_err & !keep_csum_err)) & !fwd_err_frames);
  wire wr_end    = in_valid & in_last;
  wire rewind    = wr_end & discard & !open_now;
  wire wr_tail   = wr_end & !rewind;
  wire room      = used < BODY_MAX;
  wire wr_body   = in_valid & !in_last & !ovf_r & room;
  wire body_full = in_valid & !in_last & !ovf_r & !room;
  wire do_wr     = wr_body | wr_tail;
  wire do_flush  = no_buf & !hold_on_nobuf & !rd_mid & (rd_ptr != commit_ptr);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr[AW-1:0]] <= {wr_tail & (any_err | ovf_r), wr_tail, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr      <= '0;
      commit_ptr  <= '0;
      rd_ptr      <= '0;
      ovf_r       <= 1'b0;
      open_r      <= 1'b0;
      rd_mid      <= 1'b0;
      frame_drop  <= 1'b0;
      frame_flush <= 1'b0;
    end else begin
      frame_drop  <= rewind;
      frame_flush <= do_flush;
      if (rewind) wr_ptr <= commit_ptr;
      else if (do_wr) wr_ptr <= wr_ptr + ONE;
      if (wr_tail) commit_ptr <= wr_ptr + ONE;
      if (wr_end) begin
        ovf_r  <= 1'b0;
        open_r <= 1'b0;
      end else begin
        if (body_full) ovf_r <= 1'b1;
        open_r <= open_now;
      end
      if (do_flush) rd_ptr <= commit_ptr;
      else if (pop) rd_ptr <= rd_ptr + ONE;
      if (pop) rd_mid <= !out_last;
    end
  end
endmodule

// File: rtl/rx_frame_fifo_chk.sv
module rx_frame_fifo_chk #(
  parameter int DEPTH = 2048,
  parameter int DW = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_last,
  input logic                       no_buf,
  input logic                       hold_on_nobuf,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DW-1:0]              out_data,
  input logic                       frame_drop,
  input logic                       frame_flush,
  input logic [$clog2(DEPTH):0]     used
);
  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(used) <= DEPTH);

  assert_drop_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> $past(in_valid && in_last));

  assert_flush_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_flush |-> $past(no_buf && !hold_on_nobuf));

  assert_hold_no_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (no_buf && hold_on_nobuf) |=> !frame_flush);

  assert_stall_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !no_buf) |=> (no_buf || (out_valid && $stable(out_data))));
endmodule

bind rx_frame_fifo rx_frame_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .no_buf(no_buf), .hold_on_nobuf(hold_on_nobuf), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .frame_drop(frame_drop),
  .frame_flush(frame_flush), .used(used)
);

// File: tb/rx_frame_fifo_bench.sv
module rx_frame_fifo_bench;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 0, in_last = 0, in_mac_err = 0, in_csum_err = 0;
  logic [7:0] in_data = '0;
  logic store_fwd = 1, keep_csum = 0, fwd_err = 0, hold_nb = 0, no_buf = 0;
  logic [1:0] rd_thr = 0;
  logic out_ready = 0;
  logic out_valid, out_last, out_err, frame_drop, frame_flush;
  logic [7:0] out_data;

  rx_frame_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_frame_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_mac_err(in_mac_err), .in_csum_err(in_csum_err),
    .store_fwd(store_fwd), .rd_thr(rd_thr), .keep_csum_err(keep_csum),
    .fwd_err_frames(fwd_err), .hold_on_nobuf(hold_nb), .no_buf(no_buf),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_err(out_err), .frame_drop(frame_drop),
    .frame_flush(frame_flush)
  );

  int checks = 0, errors = 0;
  int exp_drops = 0, seen_drops = 0, seen_flush = 0, fid = 0;
  bit auto_rd = 0;
  logic [9:0] expq[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int thr_of(logic [1:0] c);
    case (c)
      2'd0: return 64;
      2'd1: return 32;
      2'd2: return 96;
      default: return 128;
    endcase
  endfunction

  function automatic logic [7:0] dbyte(int f, int i);
    return 8'((f * 7 + i * 3) & 255);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      out_ready = auto_rd && ($urandom % 4 != 0);
      #1;
      if (rst_n) begin
        if (frame_drop) seen_drops++;
        if (frame_flush) seen_flush++;
        if (out_valid && out_ready) begin
          if (expq.size() == 0) chk(0, "R3 R8 unexpected byte", {out_err, out_last, out_data}, 0);
          else begin
            logic [9:0] e;
            e = expq.pop_front();
            chk({out_err, out_last, out_data} == e, "R4 R5 R6 stream byte",
                {out_err, out_last, out_data}, e);
          end
        end
      end
    end
  end

  task automatic send(int len, bit mac, bit cs, bit chk_open);
    int nonlast, kept, thr;
    bit ovf, open, disc, deliver;
    nonlast = len - 1;
    kept = (nonlast > DEPTH - 1) ? DEPTH - 1 : nonlast;
    ovf = nonlast > DEPTH - 1;
    thr = thr_of(rd_thr);
    open = !store_fwd && kept >= thr;
    disc = ovf || ((mac || (cs && !keep_csum)) && !fwd_err);
    deliver = !disc || open;
    fid++;
    if (deliver) begin
      for (int i = 0; i < kept; i++) expq.push_back({2'b00, dbyte(fid, i)});
      expq.push_back({ovf | mac | cs, 1'b1, dbyte(fid, nonlast)});
    end else exp_drops++;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1;
      in_data = dbyte(fid, i);
      in_last = (i == len - 1);
      in_mac_err = mac && (i == len - 1);
      in_csum_err = cs && (i == len - 1);
      @(posedge clk);
      #1;
      if (chk_open) begin
        if (i < len - 1) begin
          int cnt;
          bit exp;
          cnt = (i + 1 > DEPTH - 1) ? DEPTH - 1 : i + 1;
          exp = !store_fwd && cnt >= thr;
          if (store_fwd) chk(out_valid == exp, "R1 held while writing", out_valid, exp);
          else chk(out_valid == exp, "R2 threshold open", out_valid, exp);
        end else chk(out_valid == deliver, "R1 R2 visible after last", out_valid, deliver);
      end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; in_mac_err = 0; in_csum_err = 0;
  endtask

  task automatic drain(string tag);
    auto_rd = 1;
    for (int k = 0; k < 4000 && expq.size() != 0; k++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, {tag, " all bytes out"}, expq.size(), 0);
    chk(seen_drops == exp_drops, {tag, " drop pulses"}, seen_drops, exp_drops);
    chk(out_valid == 0, {tag, " empty after drain"}, out_valid, 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int f0;
    logic [7:0] d0;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk(out_valid == 0, "R10 reset out_valid", out_valid, 0);
    chk(frame_drop == 0, "R10 reset frame_drop", frame_drop, 0);
    chk(frame_flush == 0, "R10 reset frame_flush", frame_flush, 0);

    // R1 and R11
    store_fwd = 1; rd_thr = 2'd1; auto_rd = 0;
    send(50, 0, 0, 1);
    d0 = out_data;
    repeat (4) @(posedge clk);
    #1;
    chk(out_valid == 1, "R11 valid held", out_valid, 1);
    chk(out_data == d0, "R11 data held", out_data, d0);
    drain("R1");

    // R2 each threshold code
    for (int c = 0; c < 4; c++) begin
      store_fwd = 0; rd_thr = 2'(c); auto_rd = 0;
      send(thr_of(2'(c)) + 5, 0, 0, 1);
      drain("R2");
    end
    rd_thr = 2'd0; auto_rd = 0;
    send(20, 0, 0, 1);
    drain("R2 short frame");

    // R3 R4 R5 in store-and-forward
    store_fwd = 1; fwd_err = 0; keep_csum = 0;
    send(30, 1, 0, 0); drain("R3");
    send(30, 0, 1, 0); drain("R4 csum dropped");
    keep_csum = 1;
    send(30, 0, 1, 0); drain("R4 csum kept");
    send(30, 1, 1, 0); drain("R4 mac wins");
    fwd_err = 1;
    send(30, 1, 0, 0); drain("R5");
    send(30, 1, 1, 0); drain("R5");
    fwd_err = 0; keep_csum = 0;

    // R6
    store_fwd = 0; rd_thr = 2'd1; auto_rd = 0;
    send(50, 1, 0, 1); drain("R6 open error flagged");
    auto_rd = 0;
    send(20, 1, 0, 1); drain("R6 closed error dropped");

    // R7
    store_fwd = 1; auto_rd = 0;
    send(300, 0, 0, 0); drain("R7 sf overflow");
    auto_rd = 0;
    send(40, 0, 0, 0); drain("R7 after rewind");
    store_fwd = 0; rd_thr = 2'd1; auto_rd = 0;
    send(300, 0, 0, 0); drain("R7 ct overflow");

    // R8
    store_fwd = 1; no_buf = 1; hold_nb = 0; auto_rd = 1;
    f0 = seen_flush;
    send(30, 0, 0, 0);
    repeat (3) @(negedge clk);
    send(25, 0, 0, 0);
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 0, "R8 gated while no_buf", out_valid, 0);
    chk(seen_flush - f0 == 2, "R8 flush pulses", seen_flush - f0, 2);
    expq.delete();
    no_buf = 0;
    repeat (20) @(negedge clk);
    #1;
    chk(out_valid == 0, "R8 nothing left", out_valid, 0);

    // R9
    no_buf = 1; hold_nb = 1; auto_rd = 1;
    f0 = seen_flush;
    send(30, 0, 0, 0);
    send(25, 0, 0, 0);
    repeat (20) @(negedge clk);
    #1;
    chk(out_valid == 0, "R9 gated while held", out_valid, 0);
    chk(seen_flush == f0, "R9 no flush", seen_flush, f0);
    chk(expq.size() == 2 + 29 + 24, "R9 nothing consumed", expq.size(), 55);
    @(negedge clk);
    no_buf = 0; hold_nb = 0;
    drain("R9");

    // random mix
    for (int n = 0; n < 150; n++) begin
      while (expq.size() > 100) @(negedge clk);
      store_fwd = ($urandom % 2) != 0;
      rd_thr = 2'($urandom % 4);
      keep_csum = ($urandom % 2) != 0;
      fwd_err = ($urandom % 4) == 0;
      send(1 + int'($urandom % 80), ($urandom % 6) == 0, ($urandom % 5) == 0, 0);
      repeat ($urandom % 4) @(negedge clk);
    end
    drain("R3 R4 R5 R6 random");

    finish_run();
  end
endmodule